// File: doc/BRIEF.md
# SPI Serial EEPROM Responder

This block is an SPI target (clock mode 0) that looks to a host like a small byte-addressed serial EEPROM. Its storage is on-chip registers. The host frames each command with an active-low chip select. A one-byte opcode comes first. It can set or clear a write-enable latch, read or write a status byte, read data as a stream, or write data. Address bytes follow the read and write opcodes, most significant byte first. An optional ninth address bit travels inside the opcode.

Write data is held in a page buffer and written to the array only when chip select rises. A write wraps around inside its page. After each array write or status write, the responder reports not-ready for a programmable number of clock cycles. While not-ready it accepts only status reads. Two status bits select a protected region at the top of the array, and writes that land there are dropped.

SPI lines are brought into the system clock domain through two-flop synchronizers. For that reason the serial clock must be several times slower than the system clock.

Top module: `spi_eeprom_resp`

## Requirements
- R1: The status byte reads as follows: bit 0 is not-ready, bit 1 is the write-enable latch, bits 3:2 are the block-protect field and bit 7 is a stored protect-enable flag. Bits 6:4 always read 0, and the whole byte is 0x00 after reset.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 returns the live status byte on every following byte for as long as chip select stays low.
- R3: Opcodes 0x02 (write data) and 0x01 (write status) are ignored when the write-enable latch is clear. When either one is accepted, the latch clears as chip select rises.
- R4: After a read or write opcode come ADDR_BYTES address bytes, most significant byte first. With NINE_BIT set, opcode bit 3 supplies address bit 8, so 0x0B reads and 0x0A writes in the upper 256 bytes.
- R5: Opcode 0x03 streams bytes from sequential addresses while chip select stays low. After the last address it wraps to address 0.
- R6: Write data that runs past the end of a PAGE_BYTES page continues at the start of the same page. Other pages are left untouched.
- R7: The array changes only when chip select rises. Only bytes whose eight bits were all received are written; a trailing partial byte is discarded.
- R8: A committed data write or status write holds status bit 0 high for BUSY_CYCLES clock cycles. After that the bit returns to 0.
- R9: While status bit 0 is high, every opcode except 0x05 is ignored. This includes 0x06.
- R10: A status write stores data bits 7, 3 and 2. Block-protect value 01 protects the upper quarter of the array, 10 protects the upper half and 11 protects all of it. Write bytes aimed at protected addresses are dropped.
- R11: MOSI is sampled on rising SCLK and MISO changes after falling SCLK, most significant bit first. MISO is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
MISO moves three system-clock edges after SCLK falls: two synchronizer stages, then the transmit register. The bench therefore samples MISO a full half SCLK period after each falling edge, just before it raises SCLK again. A received byte is acted on one cycle after its eighth rising edge is seen. Array writes, the status update and the start of the busy interval all land on the third clock edge after chip select rises, so the bench waits eight cycles after every deselect before it looks at anything. To test the not-ready window, the bench reads status immediately after a commit, well inside BUSY_CYCLES. It then idles for BUSY_CYCLES plus a margin before it expects the ready state again.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OP_WEN_SET = 8'h06;
  localparam byte_t OP_WEN_CLR = 8'h04;
  localparam byte_t OP_STAT_RD = 8'h05;
  localparam byte_t OP_STAT_WR = 8'h01;
  localparam byte_t OP_READ    = 8'h03;
  localparam byte_t OP_WRITE   = 8'h02;
  localparam byte_t OP_HI_BIT  = 8'h08;

  typedef enum logic [2:0] {
    C_OPC, C_ADDR, C_RD, C_WR, C_SRD, C_SWR, C_SKIP
  } cmd_st_t;
endpackage

// File: rtl/ee_spi_link.sv
module ee_spi_link
  import ee_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_i,
  input  logic  cs_n_i,
  input  logic  mosi_i,
  input  byte_t tx_byte_i,
  output logic  rx_valid_o,
  output byte_t rx_byte_o,
  output logic  frame_start_o,
  output logic  frame_end_o,
  output logic  miso_o
);
  logic [2:0] s_sclk, s_cs;
  logic [1:0] s_mosi;
  logic       cs_act, sclk_rise, sclk_fall, mosi_s;
  logic [2:0] bit_q, bit_d;
  byte_t      rsh_q, rsh_d, tsh_q, tsh_d, rxb_q, rxb_d;
  logic       rxv_q, rxv_d;

  assign cs_act        = ~s_cs[1];
  assign sclk_rise     = s_sclk[1] & ~s_sclk[2];
  assign sclk_fall     = ~s_sclk[1] & s_sclk[2];
  assign mosi_s        = s_mosi[1];
  assign frame_start_o = ~s_cs[1] & s_cs[2];
  assign frame_end_o   = s_cs[1] & ~s_cs[2];

  always_comb begin
    bit_d = bit_q;
    rsh_d = rsh_q;
    tsh_d = tsh_q;
    rxb_d = rxb_q;
    rxv_d = 1'b0;
    if (!cs_act) begin
      bit_d = '0;
      tsh_d = '0;
    end else if (sclk_rise) begin
      rsh_d = {rsh_q[6:0], mosi_s};
      bit_d = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        rxv_d = 1'b1;
        rxb_d = {rsh_q[6:0], mosi_s};
      end
    end else if (sclk_fall) begin
      if (bit_q == 3'd0) tsh_d = tx_byte_i;
      else               tsh_d = {tsh_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= '0;
      s_cs   <= '1;
      s_mosi <= '0;
      bit_q  <= '0;
      rsh_q  <= '0;
      tsh_q  <= '0;
      rxb_q  <= '0;
      rxv_q  <= 1'b0;
    end else begin
      s_sclk <= {s_sclk[1:0], sclk_i};
      s_cs   <= {s_cs[1:0], cs_n_i};
      s_mosi <= {s_mosi[0], mosi_i};
      bit_q  <= bit_d;
      rsh_q  <= rsh_d;
      tsh_q  <= tsh_d;
      rxb_q  <= rxb_d;
      rxv_q  <= rxv_d;
    end
  end

  assign rx_valid_o = rxv_q;
  assign rx_byte_o  = rxb_q;
  assign miso_o     = cs_act & tsh_q[7];

  // R11: a new frame always starts on a byte boundary
  p_frame_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act) |=> (bit_q == 3'd0));
  // R11: MISO stays low while deselected
  p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$rose(s_cs[1])) |=> !miso_o);
endmodule

// File: rtl/ee_array.sv
module ee_array
  import ee_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit_i,
  input  logic [AW-PW-1:0]        page_i,
  input  logic [PAGE_BYTES*8-1:0] buf_i,
  input  logic [PAGE_BYTES-1:0]   vld_i,
  input  logic [1:0]              bp_i,
  input  logic [AW-1:0]           rd_addr_i,
  output byte_t                   rd_data_o
);
  logic [MEM_BYTES*8-1:0] flat;
  logic [MEM_BYTES-1:0]   wr_en;

  for (genvar w = 0; w < MEM_BYTES; w++) begin : g_word
    localparam int  OFF  = w % PAGE_BYTES;
    localparam int  PG   = w / PAGE_BYTES;
    localparam bit  IN_Q = (w >= MEM_BYTES - MEM_BYTES / 4);
    localparam bit  IN_H = (w >= MEM_BYTES / 2);
    logic  prot;
    byte_t word_q;

    assign prot = (bp_i == 2'b11) || (bp_i == 2'b10 && IN_H) ||
                  (bp_i == 2'b01 && IN_Q);
    assign wr_en[w] = commit_i && (page_i == (AW-PW)'(PG)) && vld_i[OFF] && !prot;

    always_ff @(posedge clk) begin
      if (wr_en[w]) word_q <= buf_i[OFF*8 +: 8];
    end
    assign flat[w*8 +: 8] = word_q;
  end

  assign rd_data_o = flat[rd_addr_i*8 +: 8];

  // R6: one commit never touches more than one page worth of words
  p_page_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) <= PAGE_BYTES);
endmodule

// File: rtl/ee_cmd_ctrl.sv
module ee_cmd_ctrl
  import ee_pkg::*;
#(
  parameter int ADDR_BYTES  = 1,
  parameter bit NINE_BIT    = 1'b1,
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 300,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int BW = $clog2(BUSY_CYCLES + 1)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid_i,
  input  byte_t                   rx_byte_i,
  input  logic                    frame_start_i,
  input  logic                    frame_end_i,
  input  byte_t                   rd_data_i,
  output byte_t                   tx_byte_o,
  output logic [AW-1:0]           rd_addr_o,
  output logic                    commit_o,
  output logic [AW-PW-1:0]        page_o,
  output logic [PAGE_BYTES*8-1:0] buf_o,
  output logic [PAGE_BYTES-1:0]   vld_o,
  output logic [1:0]              bp_o
);
  cmd_st_t st_q, st_d;
  logic [1:0]   acnt_q, acnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic         isrd_q, isrd_d, wen_q, wen_d, wpen_q, wpen_d;
  logic         busy_q, busy_d, wrcmd_q, wrcmd_d, sgot_q, sgot_d;
  logic [1:0]   bp_q, bp_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [PAGE_BYTES*8-1:0] buf_q, buf_d;
  logic [PAGE_BYTES-1:0]   vld_q, vld_d;
  logic [PW-1:0]           woff_q, woff_d;
  logic [AW-PW-1:0]        wpage_q, wpage_d;
  byte_t        srx_q, srx_d, status;
  logic         is_rd_op, is_wr_op, scommit, start_busy;

  assign status   = {wpen_q, 3'b000, bp_q, wen_q, busy_q};
  assign is_rd_op = (rx_byte_i == OP_READ) ||
                    (NINE_BIT && rx_byte_i == (OP_READ | OP_HI_BIT));
  assign is_wr_op = (rx_byte_i == OP_WRITE) ||
                    (NINE_BIT && rx_byte_i == (OP_WRITE | OP_HI_BIT));
  assign commit_o   = frame_end_i && (st_q == C_WR) && (|vld_q);
  assign scommit    = frame_end_i && (st_q == C_SWR) && sgot_q;
  assign start_busy = commit_o || scommit;

  always_comb begin
    st_d = st_q;   acnt_d = acnt_q; addr_d = addr_q; isrd_d = isrd_q;
    wen_d = wen_q; wpen_d = wpen_q; bp_d = bp_q;     wrcmd_d = wrcmd_q;
    sgot_d = sgot_q; srx_d = srx_q; buf_d = buf_q;   vld_d = vld_q;
    woff_d = woff_q; wpage_d = wpage_q;
    busy_d = busy_q; bcnt_d = bcnt_q;

    if (frame_start_i) begin
      st_d = C_OPC; wrcmd_d = 1'b0; sgot_d = 1'b0;
    end else if (rx_valid_i) begin
      unique case (st_q)
        C_OPC: begin
          acnt_d = '0;
          addr_d = AW'(NINE_BIT & rx_byte_i[3]);
          st_d   = C_SKIP;
          if (!busy_q || rx_byte_i == OP_STAT_RD) begin
            if (rx_byte_i == OP_WEN_SET)      wen_d = 1'b1;
            else if (rx_byte_i == OP_WEN_CLR) wen_d = 1'b0;
            else if (rx_byte_i == OP_STAT_RD) st_d = C_SRD;
            else if (rx_byte_i == OP_STAT_WR && wen_q) begin
              st_d = C_SWR; wrcmd_d = 1'b1;
            end else if (is_rd_op) begin
              st_d = C_ADDR; isrd_d = 1'b1;
            end else if (is_wr_op && wen_q) begin
              st_d = C_ADDR; isrd_d = 1'b0; wrcmd_d = 1'b1;
            end
          end
        end
        C_ADDR: begin
          addr_d = AW'({addr_q, rx_byte_i});
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'(ADDR_BYTES - 1)) begin
            if (isrd_q) st_d = C_RD;
            else begin
              st_d    = C_WR;
              wpage_d = addr_d[AW-1:PW];
              woff_d  = addr_d[PW-1:0];
              vld_d   = '0;
            end
          end
        end
        C_RD: addr_d = addr_q + AW'(1);
        C_WR: begin
          buf_d[woff_q*8 +: 8] = rx_byte_i;
          vld_d[woff_q]        = 1'b1;
          woff_d               = woff_q + PW'(1);
        end
        C_SWR: if (!sgot_q) begin
          srx_d = rx_byte_i; sgot_d = 1'b1;
        end
        default: ;
      endcase
    end

    if (frame_end_i) begin
      st_d = C_OPC;
      if (wrcmd_q) wen_d = 1'b0;
      if (scommit) begin
        bp_d = srx_q[3:2]; wpen_d = srx_q[7];
      end
    end

    if (start_busy) begin
      busy_d = 1'b1; bcnt_d = BW'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (bcnt_q == '0) busy_d = 1'b0;
      else              bcnt_d = bcnt_q - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= C_OPC;  acnt_q <= '0;  addr_q <= '0;  isrd_q <= 1'b0;
      wen_q <= 1'b0;  wpen_q <= 1'b0; bp_q <= '0;   wrcmd_q <= 1'b0;
      sgot_q <= 1'b0; srx_q <= '0;   buf_q <= '0;   vld_q <= '0;
      woff_q <= '0;   wpage_q <= '0; busy_q <= 1'b0; bcnt_q <= '0;
    end else begin
      st_q <= st_d;   acnt_q <= acnt_d; addr_q <= addr_d; isrd_q <= isrd_d;
      wen_q <= wen_d; wpen_q <= wpen_d; bp_q <= bp_d;     wrcmd_q <= wrcmd_d;
      sgot_q <= sgot_d; srx_q <= srx_d; buf_q <= buf_d;   vld_q <= vld_d;
      woff_q <= woff_d; wpage_q <= wpage_d; busy_q <= busy_d; bcnt_q <= bcnt_d;
    end
  end

  assign tx_byte_o = (st_q == C_RD) ? rd_data_i : status;
  assign rd_addr_o = addr_q;
  assign page_o    = wpage_q;
  assign buf_o     = buf_q;
  assign vld_o     = vld_q;
  assign bp_o      = bp_q;

  // R3: the array is only written while the latch is set
  p_wel_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> wen_q);
  // R3: an accepted write command drops the latch at deselect
  p_wel_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && wrcmd_q) |=> !wen_q);
  // R8: busy begins only at the end of a frame
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(frame_end_i));
  // R8: busy ends when its count is spent
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bcnt_q == '0 && !frame_end_i) |=> !busy_q);
  // R9: while busy, an opcode can only lead to a status read or be skipped
  p_busy_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && st_q == C_OPC && busy_q && !frame_end_i && !frame_start_i)
      |=> ((st_q == C_SRD || st_q == C_SKIP) && $stable(wen_q)));
endmodule

// File: rtl/spi_eeprom_resp.sv
module spi_eeprom_resp
  import ee_pkg::*;
#(
  parameter int ADDR_BYTES  = 1,
  parameter bit NINE_BIT    = 1'b1,
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 300
)(
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  byte_t rx_byte, tx_byte, rd_data;
  logic  rx_valid, frame_start, frame_end, commit;
  logic [AW-1:0]           rd_addr;
  logic [AW-PW-1:0]        page;
  logic [PAGE_BYTES*8-1:0] pbuf;
  logic [PAGE_BYTES-1:0]   vld;
  logic [1:0]              bp;

  ee_spi_link u_link (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .tx_byte_i(tx_byte), .rx_valid_o(rx_valid),
    .rx_byte_o(rx_byte), .frame_start_o(frame_start),
    .frame_end_o(frame_end), .miso_o(spi_miso)
  );

  ee_cmd_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .NINE_BIT(NINE_BIT), .MEM_BYTES(MEM_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .frame_start_i(frame_start), .frame_end_i(frame_end),
    .rd_data_i(rd_data), .tx_byte_o(tx_byte), .rd_addr_o(rd_addr),
    .commit_o(commit), .page_o(page), .buf_o(pbuf), .vld_o(vld), .bp_o(bp)
  );

  ee_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(page),
    .buf_i(pbuf), .vld_i(vld), .bp_i(bp), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );
endmodule

// File: tb/tb_spi_eeprom_resp.sv
`timescale 1ns/1ps
module tb_spi_eeprom_resp;
  localparam int MEM  = 512;
  localparam int PG   = 16;
  localparam int BUSY = 300;
  localparam int H    = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, fails = 0;
  int bp_m = 0;
  logic [7:0] model [MEM];
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_eeprom_resp #(.ADDR_BYTES(1), .NINE_BIT(1'b1), .MEM_BYTES(MEM),
    .PAGE_BYTES(PG), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int x);
    return 8'(x * 37 + 11 + (x >> 4));
  endfunction

  function automatic bit prot(input int a);
    return (bp_m == 3) || (bp_m == 2 && a >= MEM / 2) || (bp_m == 1 && a >= MEM - MEM / 4);
  endfunction

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, r); xfer(v, r); desel();
  endtask

  task automatic idle_busy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  // enabled: the latch is expected set, so the model is updated
  task automatic wr_bytes(input int a, input int n, input int seed, input bit enabled);
    logic [7:0] r, d;
    int base, off, t;
    base = a - (a % PG);
    sel();
    xfer(8'h02 | (8'(a >> 8) << 3), r);
    xfer(8'(a), r);
    for (int k = 0; k < n; k++) begin
      d = pat(seed + k);
      xfer(d, r);
      off = ((a % PG) + k) % PG;
      t = base + off;
      if (enabled && !prot(t)) model[t] = d;
    end
    desel();
  endtask

  task automatic rd_chk(input int a, input int n, input string req);
    logic [7:0] r;
    sel();
    xfer(8'h03 | (8'(a >> 8) << 3), r);
    xfer(8'(a), r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      chk(r === model[(a + k) % MEM], req, int'(r), int'(model[(a + k) % MEM]));
    end
    desel();
  endtask

  initial begin
    logic [7:0] s, s2, r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(miso === 1'b0, "R11 idle miso", int'(miso), 0);
    rdsr(s);
    chk(s === 8'h00, "R1 reset status", int'(s), 0);

    cmd1(8'h06);
    sel(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, s2); desel();
    chk(s === 8'h02, "R2 wen set", int'(s), 2);
    chk(s2 === 8'h02, "R2 repeated status", int'(s2), 2);
    cmd1(8'h04);
    rdsr(s);
    chk(s === 8'h00, "R2 wen clear", int'(s), 0);
    chk(miso === 1'b0, "R11 miso after deselect", int'(miso), 0);

    // fill the whole array page by page (R4 upper half via opcode bit 3)
    for (int p = 0; p < MEM / PG; p++) begin
      cmd1(8'h06);
      wr_bytes(p * PG, PG, p * PG, 1'b1);
      if (p == 0) begin
        rdsr(s);
        chk(s === 8'h01, "R8 busy and R3 latch cleared", int'(s), 1);
        cmd1(8'h06);
        idle_busy();
        rdsr(s);
        chk(s === 8'h00, "R9 wen ignored while busy, R8 ready", int'(s), 0);
      end else begin
        idle_busy();
      end
    end

    rd_chk(0, MEM + 1, "R5 full sweep");
    rd_chk(MEM - 8, 16, "R4 upper read and R5 wrap");

    cmd1(8'h06);
    wr_bytes(8'h3E, 4, 900, 1'b1);
    idle_busy();
    rd_chk(8'h30, 2 * PG, "R6 page wrap");

    cmd1(8'h06);
    sel(); xfer(8'h02, r); xfer(8'h50, r); xfer(8'hA5, r); xbits(8'h3C, 3, r); desel();
    model[8'h50] = 8'hA5;
    idle_busy();
    rd_chk(8'h50, 2, "R7 partial byte");

    wr_bytes(8'h60, 4, 700, 1'b0);
    rdsr(s);
    chk(s === 8'h00, "R3 write without latch", int'(s), 0);
    rd_chk(8'h60, 4, "R3 data unchanged");

    wrsr(8'h0C);
    rdsr(s);
    chk(s === 8'h00, "R3 status write without latch", int'(s), 0);

    cmd1(8'h06);
    wrsr(8'hFF);
    rdsr(s);
    chk(s === 8'h8D, "R1 R8 status write busy", int'(s), 8'h8D);
    idle_busy();
    rdsr(s);
    chk(s === 8'h8C, "R1 R10 stored bits", int'(s), 8'h8C);
    bp_m = 3;
    cmd1(8'h06);
    wr_bytes(0, 4, 300, 1'b1);
    idle_busy();
    rd_chk(0, 4, "R10 all protected");

    cmd1(8'h06); wrsr(8'h08); idle_busy(); bp_m = 2;
    rdsr(s);
    chk(s === 8'h08, "R10 half", int'(s), 8'h08);
    cmd1(8'h06); wr_bytes(8'hF8, PG, 400, 1'b1); idle_busy();
    cmd1(8'h06); wr_bytes(9'h100, 4, 450, 1'b1); idle_busy();
    rd_chk(8'hF0, 2 * PG, "R10 upper half protected");

    cmd1(8'h06); wrsr(8'h04); idle_busy(); bp_m = 1;
    cmd1(8'h06); wr_bytes(9'h17C, 8, 500, 1'b1); idle_busy();
    cmd1(8'h06); wr_bytes(9'h180, 4, 550, 1'b1); idle_busy();
    rd_chk(9'h170, 2 * PG, "R10 upper quarter protected");

    cmd1(8'h06); wrsr(8'h00); idle_busy(); bp_m = 0;
    rdsr(s);
    chk(s === 8'h00, "R10 protection cleared", int'(s), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule